// File: doc/BRIEF.md
# Dual Ramp Envelope Generator

This block produces two slowly moving 6-bit levels, one used as an output volume and one used as a modulation gain. Each level is a linear ramp that either climbs toward a ceiling or falls toward zero by one step each time its own timer expires. The timer length is the product of the envelope's own 6-bit speed and a shared 8-bit master speed, times eight. A software-visible write port loads each envelope's control byte and the master speed. A small read port returns either level with a fixed marker bit set.

Two halt inputs, driven from the surrounding sound unit, gate stepping. The wave halt pauses both timers and keeps their counts. The envelope halt clears both timers and keeps them at zero. If an envelope's control byte is written with its disable bit set, the envelope stops stepping and its level is loaded at once from the speed field. This lets software set a fixed level directly.

Top module: `dual_ramp_env`

## Requirements
- R1: `cfg_addr` selects the target of a write strobed by `cfg_we`. 0 is the volume control byte, 1 is the gain control byte, and 2 is the master speed. A write to address 3 changes no level, no timer and no setting.
- R2: A control byte has three fields. Bit 7 is disable, bit 6 is direction (1 = increase, 0 = decrease) and bits 5:0 are speed. A write with bit 7 set loads the level with the speed field on the write edge. A disabled envelope never steps.
- R3: An enabled envelope steps once every (speed+1)×master×8 running clocks. A write to its control byte clears its timer, so the first step comes exactly one full period after the write edge. A write with the disable bit clear leaves the level unchanged.
- R4: An increasing envelope adds 1 only while its level is below 32. A level at or above 32 holds. A decreasing envelope subtracts 1 down to 0 and then holds.
- R5: Timers run only while `wave_halt` and `env_halt` are both low and the master speed is nonzero. Raising `wave_halt` freezes both timers with their counts intact, and freezes both levels.
- R6: A master speed write clears both timers. `env_halt` held high also keeps both timers at zero.
- R7: After reset both envelopes are disabled, decreasing and at speed 0. Both levels are 0 and the master speed is 0xFF.
- R8: `rd_data` returns the volume level when `rd_sel` is 0 and the gain level when it is 1. Bit 6 is set, bit 7 is clear and the level sits in bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe |
| cfg_addr | input | 2 | Write target (0 volume, 1 gain, 2 master, 3 none) |
| cfg_data | input | 8 | Write data |
| wave_halt | input | 1 | Pause timers, keep counts |
| env_halt | input | 1 | Pause and clear timers |
| rd_sel | input | 1 | Readback select (0 volume, 1 gain) |
| vol_level | output | 6 | Volume envelope level |
| gain_level | output | 6 | Gain envelope level |
| rd_data | output | 8 | Selected level with marker bit 6 set |

## Verification
The hardest case to reach is a timer stopped partway through a period. Only then can a bench tell a pause that keeps the count apart from one that clears it, and the count is not visible at the ports. The stimulus loads a known level, enables a period-8 ramp and waits four clocks. It then applies wave halt, envelope halt, a master write or a write to the unused address. It then counts the clocks to the next step. A kept count gives a step four clocks after release and a cleared count gives one eight clocks after. The ceiling is reached by loading 30 or 63 through the disable path and then enabling an increase, so no long ramp is needed.

// File: rtl/dre_pkg.sv
// Shared widths, address codes and the control byte layout for the
// dual ramp envelope generator. Assumes an 8-bit write data path.
package dre_pkg;
    parameter int SPD_W   = 6;
    parameter int LVL_W   = 6;
    parameter int MST_W   = 8;
    parameter int LVL_MAX = 32;
    parameter int NUM_ENV = 2;
    localparam int TMR_W  = SPD_W + 1 + MST_W + 3;
    localparam int CFG_W  = SPD_W + 2;

    localparam logic [1:0] ADDR_VOL  = 2'd0;
    localparam logic [1:0] ADDR_GAIN = 2'd1;
    localparam logic [1:0] ADDR_MST  = 2'd2;

    typedef struct packed {
        logic             dis;
        logic             inc;
        logic [SPD_W-1:0] spd;
    } env_cfg_t;
endpackage

// File: rtl/dre_period.sv
// Computes one envelope's step period in clocks: (speed+1)*master*8.
// Pure combinational; the result fits TMR_W bits for all inputs.
module dre_period
    import dre_pkg::*;
(
    input  logic [SPD_W-1:0] spd,
    input  logic [MST_W-1:0] mst,
    output logic [TMR_W-1:0] period
);
    logic [TMR_W-1:0] spd_x;
    logic [TMR_W-1:0] mst_x;

    // Widen both factors and form the shifted product
    always_comb begin
        spd_x  = TMR_W'(spd) + TMR_W'(1);
        mst_x  = TMR_W'(mst);
        period = (spd_x * mst_x) << 3;
    end
endmodule

// File: rtl/dre_ramp.sv
// One ramp envelope: holds its control byte, a period timer and a level.
// Assumes period >= 8 whenever run is high (master speed nonzero).
module dre_ramp
    import dre_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  env_cfg_t         wr_val,
    input  logic             tmr_clr,
    input  logic             run,
    input  logic [TMR_W-1:0] period,
    output env_cfg_t         cfg,
    output logic [LVL_W-1:0] level
);
    logic [TMR_W-1:0] timer;
    logic             expire;
    logic             step;

    // Decide whether this edge ends a period and moves the level
    always_comb begin
        expire = run && !cfg.dis && (timer == period - TMR_W'(1));
        step   = expire && !wr_en && !tmr_clr;
    end

    // Control byte register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{dis: 1'b1, inc: 1'b0, spd: '0};
        end else if (wr_en) begin
            cfg <= wr_val;
        end
    end

    // Period timer: cleared by writes and halts, wraps at the period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer <= '0;
        end else if (wr_en || tmr_clr) begin
            timer <= '0;
        end else if (run && !cfg.dis) begin
            timer <= expire ? '0 : timer + TMR_W'(1);
        end
    end

    // Level: direct load on disable, clamped single steps otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else if (wr_en && wr_val.dis) begin
            level <= LVL_W'(wr_val.spd);
        end else if (step) begin
            if (cfg.inc) begin
                if (level < LVL_W'(LVL_MAX)) level <= level + LVL_W'(1);
            end else begin
                if (level != '0) level <= level - LVL_W'(1);
            end
        end
    end
endmodule

// File: rtl/dual_ramp_env.sv
// Top of the dual ramp envelope generator: decodes writes, keeps the
// shared master speed, gates the two ramps and muxes the readback.
// Assumes cfg_addr/cfg_data are valid whenever cfg_we is high.
module dual_ramp_env
    import dre_pkg::*;
#(
    parameter logic [MST_W-1:0] MST_RESET = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             wave_halt,
    input  logic             env_halt,
    input  logic             rd_sel,
    output logic [LVL_W-1:0] vol_level,
    output logic [LVL_W-1:0] gain_level,
    output logic [LVL_W+1:0] rd_data
);
    logic [MST_W-1:0] mst_spd;
    logic             mst_we;
    logic             run;
    logic             tmr_clr;
    logic [LVL_W-1:0] lvl [NUM_ENV];

    // Global gating shared by both ramps
    always_comb begin
        mst_we  = cfg_we && (cfg_addr == ADDR_MST);
        run     = !wave_halt && !env_halt && (mst_spd != '0);
        tmr_clr = mst_we || env_halt;
    end

    // Master speed register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mst_spd <= MST_RESET;
        end else if (mst_we) begin
            mst_spd <= cfg_data[MST_W-1:0];
        end
    end

    for (genvar ch = 0; ch < NUM_ENV; ch++) begin : g_env
        logic             wr_ch;
        env_cfg_t         cfg_q;
        logic [TMR_W-1:0] period;

        assign wr_ch = cfg_we && (cfg_addr == 2'(ch));

        dre_period u_period (
            .spd    (cfg_q.spd),
            .mst    (mst_spd),
            .period (period)
        );

        dre_ramp u_ramp (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_ch),
            .wr_val  (env_cfg_t'(cfg_data)),
            .tmr_clr (tmr_clr),
            .run     (run),
            .period  (period),
            .cfg     (cfg_q),
            .level   (lvl[ch])
        );
    end

    // Output levels and marked readback
    always_comb begin
        vol_level  = lvl[0];
        gain_level = lvl[1];
        rd_data    = {1'b0, 1'b1, (rd_sel ? lvl[1] : lvl[0])};
    end
endmodule

// File: rtl/dre_checker.sv
// Port-level properties of the dual ramp envelope generator, bound to
// every instance of the top module.
module dre_checker
    import dre_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [1:0]       cfg_addr,
    input logic [CFG_W-1:0] cfg_data,
    input logic             wave_halt,
    input logic             env_halt,
    input logic             rd_sel,
    input logic [LVL_W-1:0] vol_level,
    input logic [LVL_W-1:0] gain_level,
    input logic [LVL_W+1:0] rd_data
);
    AST_VOL_DISABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_VOL && cfg_data[7]) |=> vol_level == LVL_W'($past(cfg_data[5:0]))); // R2

    AST_GAIN_DISABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_GAIN && cfg_data[7]) |=> gain_level == LVL_W'($past(cfg_data[5:0]))); // R2

    AST_VOL_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_addr == ADDR_VOL) |=>
        (vol_level == $past(vol_level) || vol_level == $past(vol_level) + LVL_W'(1)
         || vol_level == $past(vol_level) - LVL_W'(1))); // R4

    AST_VOL_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cfg_we && cfg_addr == ADDR_VOL) && vol_level >= LVL_W'(LVL_MAX)) |=> !(vol_level > $past(vol_level))); // R4

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        ((wave_halt || env_halt) && !(cfg_we && (cfg_addr == ADDR_VOL || cfg_addr == ADDR_GAIN)))
        |=> ($stable(vol_level) && $stable(gain_level))); // R5

    AST_UNUSED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 2'd3 && (wave_halt || env_halt)) |=> ($stable(vol_level) && $stable(gain_level))); // R1

    AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data == {2'b01, (rd_sel ? gain_level : vol_level)}); // R8
endmodule

bind dual_ramp_env dre_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_data   (cfg_data),
    .wave_halt  (wave_halt),
    .env_halt   (env_halt),
    .rd_sel     (rd_sel),
    .vol_level  (vol_level),
    .gain_level (gain_level),
    .rd_data    (rd_data)
);

// File: tb/dual_ramp_env_tb_top.sv
// Scoreboard bench: the driver queues expected values, the monitor
// compares them against the outputs shortly after each falling edge.
module dual_ramp_env_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = 2'd0;
    logic [7:0] cfg_data = 8'd0;
    logic       wave_halt = 1'b0;
    logic       env_halt = 1'b0;
    logic       rd_sel = 1'b0;
    logic [5:0] vol_level;
    logic [5:0] gain_level;
    logic [7:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t q[$];
    item_t it;

    always #4 clk = ~clk;

    dual_ramp_env dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_data   (cfg_data),
        .wave_halt  (wave_halt),
        .env_halt   (env_halt),
        .rd_sel     (rd_sel),
        .vol_level  (vol_level),
        .gain_level (gain_level),
        .rd_data    (rd_data)
    );

    // Monitor: kind 0 volume, 1 gain, 2 readback
    always begin
        logic [7:0] act;
        @(negedge clk);
        #2;
        while (q.size() > 0) begin
            it = q.pop_front();
            act = (it.kind == 0) ? {2'b00, vol_level} :
                  (it.kind == 1) ? {2'b00, gain_level} : rd_data;
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind %0d: actual 0x%0h expected 0x%0h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic expect_val(input int kind, input logic [7:0] exp, input string req);
        item_t e;
        e.kind = kind; e.exp = exp; e.req = req;
        q.push_back(e);
        #3;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        expect_val(0, 8'd0, "R7 vol after reset");
        expect_val(1, 8'd0, "R7 gain after reset");
        expect_val(2, 8'h40, "R8 readback after reset");
        // R7: master resets to 0xFF, so speed 0 gives 2040 clocks
        wr(2'd0, 8'h40);
        wait_n(2039);
        expect_val(0, 8'd0, "R7 one clock before 2040");
        wait_n(1);
        expect_val(0, 8'd1, "R7 step at 2040");
        // R3: master 1, speed 0 -> period 8
        wr(2'd2, 8'd1);
        wr(2'd0, 8'h40);
        wait_n(7);
        expect_val(0, 8'd1, "R3 period 8 minus one");
        wait_n(1);
        expect_val(0, 8'd2, "R3 period 8 step");
        // R3: speed 2 -> period 24, enable write keeps level
        wr(2'd0, 8'h42);
        expect_val(0, 8'd2, "R3 enable write keeps level");
        wait_n(23);
        expect_val(0, 8'd2, "R3 period 24 minus one");
        wait_n(1);
        expect_val(0, 8'd3, "R3 period 24 step");
        // R4: ceiling at 32
        wr(2'd0, 8'h9E);
        expect_val(0, 8'd30, "R2 disable loads speed");
        wr(2'd0, 8'h40);
        wait_n(16);
        expect_val(0, 8'd32, "R4 reaches 32");
        wait_n(40);
        expect_val(0, 8'd32, "R4 holds at 32");
        // R4: decreasing gain floors at 0
        wr(2'd1, 8'h82);
        expect_val(1, 8'd2, "R2 gain disable load");
        wr(2'd1, 8'h00);
        wait_n(8);
        expect_val(1, 8'd1, "R4 gain decrement");
        wait_n(8);
        expect_val(1, 8'd0, "R4 gain reaches 0");
        wait_n(16);
        expect_val(1, 8'd0, "R4 gain holds at 0");
        // R5: wave halt keeps the timer count
        wr(2'd0, 8'h85);
        wr(2'd0, 8'h40);
        wait_n(4);
        wave_halt = 1'b1;
        wait_n(10);
        expect_val(0, 8'd5, "R5 frozen under wave halt");
        wave_halt = 1'b0;
        wait_n(3);
        expect_val(0, 8'd5, "R5 resume before step");
        wait_n(1);
        expect_val(0, 8'd6, "R5 resume keeps count");
        // R6: env halt clears timers
        wr(2'd0, 8'h85);
        wr(2'd0, 8'h40);
        wait_n(4);
        env_halt = 1'b1;
        wait_n(3);
        env_halt = 1'b0;
        wait_n(7);
        expect_val(0, 8'd5, "R6 env halt cleared timer");
        wait_n(1);
        expect_val(0, 8'd6, "R6 full period after env halt");
        // R6: master write clears timers
        wr(2'd0, 8'h85);
        wr(2'd0, 8'h40);
        wait_n(4);
        wr(2'd2, 8'd1);
        wait_n(7);
        expect_val(0, 8'd5, "R6 master write cleared timer");
        wait_n(1);
        expect_val(0, 8'd6, "R6 full period after master write");
        // R5: master speed zero stops stepping
        wr(2'd2, 8'd0);
        wait_n(50);
        expect_val(0, 8'd6, "R5 master zero holds");
        wr(2'd2, 8'd1);
        // R2: disabled envelope holds
        wr(2'd0, 8'h8A);
        wait_n(30);
        expect_val(0, 8'd10, "R2 disabled holds");
        // R1: address 3 touches nothing
        wr(2'd0, 8'h00);
        wait_n(4);
        wr(2'd3, 8'h80);
        expect_val(0, 8'd10, "R1 address 3 no load");
        expect_val(1, 8'd0, "R1 address 3 gain untouched");
        wait_n(1);
        expect_val(0, 8'd10, "R1 timer not cleared minus one");
        wait_n(1);
        expect_val(0, 8'd9, "R1 timer kept count");
        // R8: readback of each level
        expect_val(2, 8'h49, "R8 readback volume");
        wr(2'd1, 8'hBF);
        rd_sel = 1'b1;
        #1;
        expect_val(2, 8'h7F, "R8 readback gain");
        wr(2'd1, 8'h40);
        wait_n(8);
        expect_val(1, 8'd63, "R4 above 32 holds on increase");
        wait_n(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule